// File: doc/BRIEF.md
# Arbitrated Packet-Memory Read Port

This block gives a host CPU indirect read access to a packet memory that is shared with other bus masters, such as DMA engines. The host loads a location index into a pointer register and then reads words one after another through a single data offset. After each completed data read the pointer steps to the next location, so the host can walk through stored records such as earlier transmit status.

The memory sits behind an arbiter, modelled here as a request/grant pair. After the grant, the read data arrives one cycle later, so a read can take an unknown number of cycles. Two ways of absorbing that delay can be selected. In wait-state mode the block holds its bus-ready output low until the word has been fetched. In handshake mode, for hosts that cannot stretch a bus cycle, the block prefetches the word at the pointer. The host polls a ready flag, and the data read then completes at once.

Top module: `pmrd_port`

## Requirements
- R1: After synchronous reset the pointer is 0, the control register reads 0 (wait-state mode, ready flag clear), `mem_req` is low, and `host_rdy` is low while `host_cyc` is low.
- R2: Register offsets are: 0 = pointer (read/write), 1 = data port (read), 2 = control (bit 0 = handshake mode, read/write; bit 1 = ready flag, read-only), 3 = reads as zero. A pointer write of a value at or above DEPTH loads 0.
- R3: In wait-state mode a data-port read keeps `host_rdy` low until the word is fetched. It returns the memory word at the pointer. With a grant arriving L cycles after `mem_req` rises, `host_rdy` is low for exactly L+3 cycles of the access.
- R4: Each completed data-port read that delivers a word advances the pointer by one. Past DEPTH-1 the pointer wraps to 0.
- R5: Once raised, `mem_req` stays high with a stable `mem_addr` until `mem_gnt`. The word is taken from `mem_rdata` in the cycle after the grant.
- R6: In handshake mode, writing the pointer, or writing the control register with bit 0 set, starts a prefetch at the pointer and clears the ready flag. The flag sets when the prefetched word is captured. Every access in this mode completes without wait states.
- R7: In handshake mode a data-port read with the ready flag set returns the prefetched word. It also advances the pointer and starts the prefetch of the next location.
- R8: In handshake mode a data-port read with the ready flag clear leaves the pointer unchanged and starts no prefetch.
- R9: A pointer write during an unfinished prefetch discards the old fetch. The ready flag next sets with the word at the new pointer.
- R10: Writes to the data-port offset and to offset 3 are ignored: pointer and control contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cyc | input | 1 | Host access active; held until completion |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register offset |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data, valid while `host_rdy` is high |
| host_rdy | output | 1 | Access completes on a clock edge where this is high |
| mem_req | output | 1 | Packet memory read request to the arbiter |
| mem_addr | output | AW | Packet memory read address |
| mem_gnt | input | 1 | Arbiter grant |
| mem_rdata | input | DW | Memory data, valid the cycle after the grant |

## Verification
The bench sweeps every start pointer in both modes with a grant latency that varies from read to read. It counts wait states exactly, so a design that released `host_rdy` a cycle early would hand back a stale word, and an extra register stage would show up as a wrong count. Sequential reads that run past the last location catch a pointer that fails to wrap, or one that runs into the unused index range of a non-power-of-two depth. The handshake cases go after a flag that sets before the data is captured, a read while the flag is clear that still moves the pointer, and a pointer rewrite during an unfinished prefetch. A design that got the last case wrong would report ready with the word from the old pointer.

// File: rtl/pmrd_pkg.sv
package pmrd_pkg;

    // Register offsets on the host side
    localparam logic [1:0] OFS_PTR  = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    // Bit positions inside the control register
    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_RDY_BIT  = 1;

    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_CAP
    } fetch_st_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FETCH,
        W_HAVE
    } wait_st_e;

    // Packed so that bit 0 is mode and bit 1 is ready
    typedef struct packed {
        logic ready;
        logic mode;
    } ctrl_t;

    // Next location with wrap at the memory depth
    function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

    // Pointer load value: out-of-range values land on location zero
    function automatic int unsigned load_ptr(input int unsigned v, input int unsigned depth);
        return (v >= depth) ? 0 : v;
    endfunction

endpackage

// File: rtl/pmrd_fetch.sv
module pmrd_fetch
    import pmrd_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic [DW-1:0] fetched
);

    fetch_st_e     state;
    logic [AW-1:0] addr_q;
    logic          pend;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] word_q;

    assign mem_req  = (state == F_REQ);
    assign mem_addr = addr_q;
    assign fetched  = word_q;
    // A capture only counts when no newer launch is waiting behind it
    assign done     = (state == F_CAP) && !start && !pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= F_IDLE;
            addr_q    <= '0;
            pend      <= 1'b0;
            pend_addr <= '0;
            word_q    <= '0;
        end else begin
            case (state)
                F_IDLE: begin
                    if (start) begin
                        addr_q <= start_addr;
                        state  <= F_REQ;
                    end
                end
                F_REQ: begin
                    if (start) begin
                        pend      <= 1'b1;
                        pend_addr <= start_addr;
                    end
                    if (mem_gnt) begin
                        state <= F_CAP;
                    end
                end
                F_CAP: begin
                    if (start) begin
                        addr_q <= start_addr;
                        pend   <= 1'b0;
                        state  <= F_REQ;
                    end else if (pend) begin
                        addr_q <= pend_addr;
                        pend   <= 1'b0;
                        state  <= F_REQ;
                    end else begin
                        word_q <= mem_rdata;
                        state  <= F_IDLE;
                    end
                end
                default: state <= F_IDLE;
            endcase
        end
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R5
    cap_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_req && mem_gnt));

endmodule

// File: rtl/pmrd_regs.sv
module pmrd_regs
    import pmrd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_cyc,
    input  logic          host_we,
    input  logic [1:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdy,
    input  logic          done,
    input  logic [DW-1:0] fetched,
    output logic          start,
    output logic [AW-1:0] start_addr
);

    logic [AW-1:0] ptr;
    ctrl_t         ctrl_q;
    wait_st_e      wst;

    logic          rd_data_op;
    logic          wr_op;
    logic          data_done;
    logic [AW-1:0] ptr_inc;
    logic [AW-1:0] ptr_load;

    assign rd_data_op = host_cyc && !host_we && (host_addr == OFS_DATA);
    assign wr_op      = host_cyc && host_we;
    assign host_rdy   = host_cyc && (host_we || (host_addr != OFS_DATA) ||
                                     ctrl_q.mode || (wst == W_HAVE));
    assign data_done  = rd_data_op && host_rdy;
    assign ptr_inc    = AW'(wrap_inc(32'(ptr), DEPTH));
    assign ptr_load   = AW'(load_ptr(32'(host_wdata), DEPTH));

    // Fetch launch decision, one source per cycle
    always_comb begin
        start      = 1'b0;
        start_addr = ptr;
        if (wr_op && (host_addr == OFS_PTR) && ctrl_q.mode) begin
            start      = 1'b1;
            start_addr = ptr_load;
        end else if (wr_op && (host_addr == OFS_CTRL) && host_wdata[CTRL_MODE_BIT]) begin
            start      = 1'b1;
            start_addr = ptr;
        end else if (data_done && ctrl_q.mode && ctrl_q.ready) begin
            start      = 1'b1;
            start_addr = ptr_inc;
        end else if (rd_data_op && !ctrl_q.mode && (wst == W_IDLE)) begin
            start      = 1'b1;
            start_addr = ptr;
        end
    end

    always_comb begin
        case (host_addr)
            OFS_PTR:  host_rdata = DW'(ptr);
            OFS_DATA: host_rdata = fetched;
            OFS_CTRL: host_rdata = DW'(ctrl_q);
            default:  host_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            ctrl_q <= '0;
            wst    <= W_IDLE;
        end else begin
            // pointer
            if (wr_op && (host_addr == OFS_PTR)) begin
                ptr <= ptr_load;
            end else if (data_done && (!ctrl_q.mode || ctrl_q.ready)) begin
                ptr <= ptr_inc;
            end

            // control: mode bit and ready flag
            if (wr_op && (host_addr == OFS_CTRL)) begin
                ctrl_q.mode  <= host_wdata[CTRL_MODE_BIT];
                ctrl_q.ready <= 1'b0;
            end else if (start) begin
                ctrl_q.ready <= 1'b0;
            end else if (done && ctrl_q.mode) begin
                ctrl_q.ready <= 1'b1;
            end

            // wait-state sequencing
            case (wst)
                W_IDLE:  if (start && rd_data_op && !ctrl_q.mode) wst <= W_FETCH;
                W_FETCH: if (done) wst <= W_HAVE;
                W_HAVE:  if (data_done || wr_op) wst <= W_IDLE;
                default: wst <= W_IDLE;
            endcase
        end
    end

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr < AW'(DEPTH - 1) || ptr == AW'(DEPTH - 1));

    // R8
    hs_stall_read_chk: assert property (@(posedge clk) disable iff (rst)
        (data_done && ctrl_q.mode && !ctrl_q.ready) |=> $stable(ptr));

    // R6
    launch_clears_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !ctrl_q.ready);

    // R3
    wait_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_op && !ctrl_q.mode && host_rdy) |-> ($past(done) || $past(wst == W_HAVE)));

endmodule

// File: rtl/pmrd_port.sv
module pmrd_port
    import pmrd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_cyc,
    input  logic          host_we,
    input  logic [1:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata
);

    logic          start;
    logic [AW-1:0] start_addr;
    logic          done;
    logic [DW-1:0] fetched;

    pmrd_regs #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_cyc   (host_cyc),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_rdy   (host_rdy),
        .done       (done),
        .fetched    (fetched),
        .start      (start),
        .start_addr (start_addr)
    );

    pmrd_fetch #(.DW(DW), .AW(AW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .done       (done),
        .fetched    (fetched)
    );

endmodule

// File: tb/pmrd_port_test.sv
module pmrd_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int DEPTH = 12;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_cyc = 1'b0;
    logic          host_we = 1'b0;
    logic [1:0]    host_addr = 2'd0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rdy;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_gnt;
    logic [DW-1:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int gcnt = 0;
    int hold_viol = 0;
    logic          prev_stall = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pmrd_port #(.DW(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .host_cyc(host_cyc), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] exp_mem(input int i);
        return DW'((i * 1093) ^ 16'hC35A);
    endfunction

    // Arbiter and memory model: grant after lat cycles, data one cycle later
    assign mem_gnt = mem_req && (gcnt >= lat);
    always @(posedge clk) begin
        if (rst) begin
            gcnt      <= 0;
            mem_rdata <= '0;
        end else if (mem_gnt) begin
            gcnt      <= 0;
            mem_rdata <= exp_mem(int'(mem_addr));
        end else if (mem_req) begin
            gcnt <= gcnt + 1;
        end
    end

    // R5 request hold monitor
    always @(posedge clk) begin
        if (rst) begin
            prev_stall <= 1'b0;
        end else begin
            if (prev_stall && (!mem_req || mem_addr != prev_addr)) hold_viol++;
            prev_stall <= mem_req && !mem_gnt;
            prev_addr  <= mem_addr;
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic [1:0] a, input logic w, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output int waits);
        @(negedge clk);
        host_cyc = 1'b1; host_we = w; host_addr = a; host_wdata = d;
        waits = 0;
        #(CLK_PERIOD / 4);
        while (!host_rdy && waits < 100) begin
            waits++;
            @(negedge clk);
            #(CLK_PERIOD / 4);
        end
        rd = host_rdata;
        @(posedge clk);
        #1;
        host_cyc = 1'b0; host_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd; int w;
        bus(a, 1'b1, d, rd, w);
    endtask

    task automatic poll_ready(input string tag);
        logic [DW-1:0] rd; int w; int n;
        n = 0;
        rd = '0;
        while (!rd[1] && n < 40) begin
            bus(2'd2, 1'b0, '0, rd, w);
            n++;
        end
        check_eq(tag, 32'(rd[1]), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int w;
        int p;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_eq("R1 mem_req", 32'(mem_req), 0);
        check_eq("R1 host_rdy idle", 32'(host_rdy), 0);
        bus(2'd0, 0, '0, rd, w); check_eq("R1 ptr", 32'(rd), 0);
        bus(2'd2, 0, '0, rd, w); check_eq("R1 ctrl", 32'(rd), 0);

        // R2 register map and pointer load range
        wr(2'd0, 16'd5);  bus(2'd0, 0, '0, rd, w); check_eq("R2 ptr 5", 32'(rd), 5);
        wr(2'd0, 16'd13); bus(2'd0, 0, '0, rd, w); check_eq("R2 ptr high", 32'(rd), 0);
        wr(2'd0, 16'd11); bus(2'd0, 0, '0, rd, w); check_eq("R2 ptr 11", 32'(rd), 11);
        bus(2'd3, 0, '0, rd, w); check_eq("R2 ofs3", 32'(rd), 0);

        // R3 / R4 wait-state sweep over every start location
        for (int s = 0; s < DEPTH; s++) begin
            lat = s % 6;
            wr(2'd0, DW'(s));
            bus(2'd1, 0, '0, rd, w);
            check_eq("R3 data", 32'(rd), 32'(exp_mem(s)));
            check_eq("R3 waits", 32'(w), 32'(lat + 3));
            bus(2'd0, 0, '0, rd, w);
            check_eq("R4 ptr step", 32'(rd), 32'((s + 1) % DEPTH));
        end

        // R4 sequential reads across the wrap point
        p = DEPTH - 3;
        wr(2'd0, DW'(p));
        for (int k = 0; k < 6; k++) begin
            lat = (k * 2) % 5;
            bus(2'd1, 0, '0, rd, w);
            check_eq("R4 seq data", 32'(rd), 32'(exp_mem(p)));
            p = (p + 1) % DEPTH;
        end
        bus(2'd0, 0, '0, rd, w); check_eq("R4 wrap ptr", 32'(rd), 32'(p));

        // R10 ignored writes
        wr(2'd0, 16'd4);
        wr(2'd1, 16'hFFFF);
        bus(2'd0, 0, '0, rd, w); check_eq("R10 ptr kept", 32'(rd), 4);
        wr(2'd3, 16'h0003);
        bus(2'd2, 0, '0, rd, w); check_eq("R10 ctrl kept", 32'(rd), 0);

        // R6 / R7 entering handshake mode
        lat = 0;
        wr(2'd0, 16'd7);
        wr(2'd2, 16'd1);
        bus(2'd2, 0, '0, rd, w); check_eq("R6 ready clear", 32'(rd), 1);
        check_eq("R6 no wait", 32'(w), 0);
        poll_ready("R6 ready set");
        bus(2'd1, 0, '0, rd, w);
        check_eq("R7 data", 32'(rd), 32'(exp_mem(7)));
        check_eq("R6 data no wait", 32'(w), 0);
        bus(2'd2, 0, '0, rd, w); check_eq("R7 ready relaunch", 32'(rd), 1);
        bus(2'd0, 0, '0, rd, w); check_eq("R7 ptr", 32'(rd), 8);

        // R7 handshake sweep across the wrap
        p = 8;
        for (int k = 0; k < DEPTH + 2; k++) begin
            lat = k % 5;
            poll_ready("R7 poll");
            bus(2'd1, 0, '0, rd, w);
            check_eq("R7 sweep data", 32'(rd), 32'(exp_mem(p)));
            p = (p + 1) % DEPTH;
        end
        poll_ready("R7 final poll");

        // R8 read with ready clear
        lat = 5;
        wr(2'd0, 16'd2);
        bus(2'd1, 0, '0, rd, w);
        check_eq("R8 no wait", 32'(w), 0);
        bus(2'd0, 0, '0, rd, w); check_eq("R8 ptr kept", 32'(rd), 2);
        poll_ready("R8 poll");
        bus(2'd1, 0, '0, rd, w); check_eq("R8 data", 32'(rd), 32'(exp_mem(2)));

        // R9 pointer rewrite during an unfinished prefetch
        poll_ready("R9 settle");
        lat = 4;
        wr(2'd0, 16'd9);
        wr(2'd0, 16'd3);
        poll_ready("R9 poll");
        bus(2'd1, 0, '0, rd, w); check_eq("R9 data", 32'(rd), 32'(exp_mem(3)));
        poll_ready("R9 settle2");
        lat = 2;
        wr(2'd0, 16'd10);
        @(negedge clk);
        wr(2'd0, 16'd6);
        poll_ready("R9 poll2");
        bus(2'd1, 0, '0, rd, w); check_eq("R9 data2", 32'(rd), 32'(exp_mem(6)));
        poll_ready("R9 settle3");

        // R3 back to wait-state mode
        wr(2'd2, 16'd0);
        bus(2'd2, 0, '0, rd, w); check_eq("R3 ctrl off", 32'(rd), 0);
        lat = 3;
        wr(2'd0, 16'd1);
        bus(2'd1, 0, '0, rd, w);
        check_eq("R3 data after mode", 32'(rd), 32'(exp_mem(1)));
        check_eq("R3 waits after mode", 32'(w), 6);

        // R5 request hold over the whole run
        check_eq("R5 hold violations", 32'(hold_viol), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule